// File: doc/BRIEF.md
# Banked Window Bridge for a Secondary 8-bit CPU

This bridge gives an 8-bit CPU access to the 24-bit address space of a 16-bit host bus. The upper half of the 8-bit CPU's map ($8000–$FFFF) is a 32 KB window. A 9-bit bank register positions that window on any 32 KB boundary of the host space. The bank register is loaded one bit per write. Each access through the window becomes one byte-lane cycle on the host bus. The bridge first requests the bus and waits for grant. It keeps the 8-bit CPU in wait state until the host acknowledges the cycle.

The bridge also produces the output and write enables for host work RAM, which sits at $FF0000–$FFFFFF. It also decodes the timer/IO register page at $A130xx. The work-RAM output enables come only from the data strobes that some other master drives. The bridge's own cycles therefore never enable the RAM outputs. A bridged read of work RAM returns $FF whatever the RAM holds. Bridged writes reach the correct byte of work RAM. A read-modify-write increment through the window therefore reads $FF and stores $00.

Top module: `cpu_window_bridge`

## Requirements
- R1: A window access at 8-bit address A (A[15]=1) drives host address bits 23..15 from the bank register and bits 14..1 from A[14:1].
- R2: Each write on the bank port shifts `bank_bit` into bank bit 8 and moves the other bits down one place. After 9 writes, the first bit written is in bank bit 0. Reset clears the bank to zero.
- R3: An even 8-bit address asserts only `bus_uds` and uses host data bits 15..8. An odd address asserts only `bus_lds` and uses bits 7..0.
- R4: On `s_start` with a window address, the bridge raises `bus_breq` and `s_wait`. It asserts a strobe only once `bus_bgnt` is high. It holds the strobe until `bus_ack`, and drops `s_wait` in the cycle after the acknowledge.
- R5: A bridged read whose host address has bits 23..16 equal to $FF returns $FF on `s_rdata`, whatever the bus carries.
- R6: A bridged write into work RAM raises only the write enable of the addressed lane (`ram_we_hi` for even, `ram_we_lo` for odd). The written byte appears on that lane of `bus_wdata`, so any value $00–$FF is stored exactly.
- R7: While the bridge drives no strobe, `ram_oe_hi`/`ram_oe_lo` follow `ext_uds`/`ext_lds`. While a bridge strobe is active, both stay low.
- R8: `io_sel` is high during a bridged strobe whose host address bits 23..8 are $A130.
- R9: A bridged read outside work RAM returns the byte on the selected lane of `bus_rdata`.
- R10: `s_start` with an address below $8000 starts nothing: `s_wait` and `bus_breq` stay low.
- R11: A read-modify-write increment of a work-RAM byte through the window reads $FF and stores $00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_start | input | 1 | One-cycle access start from the 8-bit CPU |
| s_we | input | 1 | 1 = write, 0 = read |
| s_addr | input | 16 | 8-bit CPU address |
| s_wdata | input | 8 | Write byte |
| s_rdata | output | 8 | Read byte, valid when `s_wait` falls |
| s_wait | output | 1 | Wait request to the 8-bit CPU |
| bank_wr | input | 1 | Bank port write strobe |
| bank_bit | input | 1 | Bit shifted into the bank register |
| bus_breq | output | 1 | Host bus request |
| bus_bgnt | input | 1 | Host bus grant |
| bus_addr | output | 23 | Host word address, bits 23..1 |
| bus_uds | output | 1 | Upper (even) data strobe |
| bus_lds | output | 1 | Lower (odd) data strobe |
| bus_rd | output | 1 | 1 = read cycle |
| bus_wdata | output | 16 | Host write data, byte replicated on both lanes |
| bus_rdata | input | 16 | Host read data |
| bus_ack | input | 1 | Host data acknowledge |
| ext_uds | input | 1 | Upper strobe driven by another master |
| ext_lds | input | 1 | Lower strobe driven by another master |
| ext_we | input | 1 | Write qualifier from another master |
| ram_oe_hi | output | 1 | Work RAM even-byte output enable |
| ram_oe_lo | output | 1 | Work RAM odd-byte output enable |
| ram_we_hi | output | 1 | Work RAM even-byte write enable |
| ram_we_lo | output | 1 | Work RAM odd-byte write enable |
| io_sel | output | 1 | Timer/IO page select |

## Verification
The assertions assume three things about the inputs. The host keeps `bus_bgnt` high for as long as `bus_breq` is high. `bus_ack` arrives only while a strobe is active. `s_start` is pulsed only while `s_wait` is low. The bench meets these assumptions in two ways. First, it models the host side with a grant register that follows the request and an acknowledge that is raised one cycle after a strobe. Second, every access task waits for `s_wait` to fall before it issues the next pulse. External strobes are raised only in the tests that exercise the enable gating.

// File: rtl/cpu_window_bridge.sv
module cpu_window_bridge #(
  parameter int SADDR_W = 16,
  parameter int BADDR_W = 24,
  parameter logic [7:0]  RAM_TAG = 8'hFF,
  parameter logic [15:0] IO_TAG  = 16'hA130
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s_start,
  input  logic                 s_we,
  input  logic [SADDR_W-1:0]   s_addr,
  input  logic [7:0]           s_wdata,
  output logic [7:0]           s_rdata,
  output logic                 s_wait,
  input  logic                 bank_wr,
  input  logic                 bank_bit,
  output logic                 bus_breq,
  input  logic                 bus_bgnt,
  output logic [BADDR_W-1:1]   bus_addr,
  output logic                 bus_uds,
  output logic                 bus_lds,
  output logic                 bus_rd,
  output logic [15:0]          bus_wdata,
  input  logic [15:0]          bus_rdata,
  input  logic                 bus_ack,
  input  logic                 ext_uds,
  input  logic                 ext_lds,
  input  logic                 ext_we,
  output logic                 ram_oe_hi,
  output logic                 ram_oe_lo,
  output logic                 ram_we_hi,
  output logic                 ram_we_lo,
  output logic                 io_sel
);
  localparam int OFS_W  = SADDR_W - 1;
  localparam int BANK_W = BADDR_W - OFS_W;

  typedef enum logic [1:0] {IDLE, REQ, STB} st_t;

  st_t               st;
  logic [BANK_W-1:0] bank;
  logic [OFS_W-1:0]  off;
  logic              we_q;
  logic [7:0]        wd_q;
  logic [7:0]        rd_q;

  logic own, ram_hit;
  logic [7:0] lane;

  assign own      = (st == STB);
  assign bus_addr = {bank, off[OFS_W-1:1]};
  assign ram_hit  = (bus_addr[BADDR_W-1 -: 8] == RAM_TAG);
  assign lane     = off[0] ? bus_rdata[7:0] : bus_rdata[15:8];

  assign s_wait    = (st != IDLE);
  assign s_rdata   = rd_q;
  assign bus_breq  = (st != IDLE);
  assign bus_uds   = own & ~off[0];
  assign bus_lds   = own &  off[0];
  assign bus_rd    = ~we_q;
  assign bus_wdata = {wd_q, wd_q};

  assign ram_oe_hi = ~own & ext_uds;
  assign ram_oe_lo = ~own & ext_lds;
  assign ram_we_hi = own ? (ram_hit & we_q & bus_uds) : (ext_we & ext_uds);
  assign ram_we_lo = own ? (ram_hit & we_q & bus_lds) : (ext_we & ext_lds);
  assign io_sel    = own & (bus_addr[BADDR_W-1:8] == IO_TAG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= IDLE;
      bank <= '0;
      off  <= '0;
      we_q <= 1'b0;
      wd_q <= '0;
      rd_q <= '0;
    end else begin
      if (bank_wr) bank <= {bank_bit, bank[BANK_W-1:1]};
      case (st)
        IDLE: if (s_start && s_addr[SADDR_W-1]) begin
          st   <= REQ;
          off  <= s_addr[OFS_W-1:0];
          we_q <= s_we;
          wd_q <= s_wdata;
        end
        REQ: if (bus_bgnt) st <= STB;
        STB: if (bus_ack) begin
          st   <= IDLE;
          rd_q <= ram_hit ? 8'hFF : lane;
        end
        default: st <= IDLE;
      endcase
    end
  end

  assert_bank_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr |=> bank[BANK_W-1] == $past(bank_bit));
  assert_lane_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_uds, bus_lds}));
  assert_strobe_granted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_uds | bus_lds) |-> bus_bgnt);
  assert_wait_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(s_wait) |-> $past(bus_ack));
  assert_ram_read_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack && (bus_uds | bus_lds) && bus_rd && bus_addr[BADDR_W-1 -: 8] == RAM_TAG)
      |=> s_rdata == 8'hFF);
  assert_oe_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_uds | bus_lds) |-> !(ram_oe_hi | ram_oe_lo));
  assert_outside_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_wait && s_start && !s_addr[SADDR_W-1]) |=> !s_wait);
endmodule

// File: tb/tb_cpu_window_bridge.sv
module tb_cpu_window_bridge;
  logic clk = 0;
  logic rst_n = 0;
  always #4 clk = ~clk;

  logic s_start = 0, s_we = 0, bank_wr = 0, bank_bit = 0;
  logic [15:0] s_addr = 0;
  logic [7:0]  s_wdata = 0, s_rdata;
  logic s_wait, bus_breq, bus_uds, bus_lds, bus_rd, io_sel;
  logic bus_bgnt, bus_ack;
  logic [23:1] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic ext_uds = 0, ext_lds = 0, ext_we = 0;
  logic ram_oe_hi, ram_oe_lo, ram_we_hi, ram_we_lo;

  cpu_window_bridge dut (
    .clk, .rst_n, .s_start, .s_we, .s_addr, .s_wdata, .s_rdata, .s_wait,
    .bank_wr, .bank_bit, .bus_breq, .bus_bgnt, .bus_addr, .bus_uds, .bus_lds,
    .bus_rd, .bus_wdata, .bus_rdata, .bus_ack, .ext_uds, .ext_lds, .ext_we,
    .ram_oe_hi, .ram_oe_lo, .ram_we_hi, .ram_we_lo, .io_sel);

  logic [15:0] mem [256];
  logic        fill_en = 0;
  logic [7:0]  fill_idx = 0;
  logic [15:0] fill_val = 0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_bgnt <= 1'b0;
      bus_ack  <= 1'b0;
    end else begin
      bus_bgnt <= bus_breq;
      bus_ack  <= (bus_uds | bus_lds) & ~bus_ack;
    end
    if (fill_en) mem[fill_idx] <= fill_val;
    if (ram_we_hi) mem[bus_addr[8:1]][15:8] <= bus_wdata[15:8];
    if (ram_we_lo) mem[bus_addr[8:1]][7:0]  <= bus_wdata[7:0];
  end

  assign bus_rdata = (bus_addr[23:16] == 8'hFF) ? mem[bus_addr[8:1]]
                                                : {~bus_addr[8:1], bus_addr[8:1]};

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] idx, input logic [15:0] val);
    @(negedge clk); fill_en = 1; fill_idx = idx; fill_val = val;
    @(negedge clk); fill_en = 0;
  endtask

  task automatic set_bank(input logic [8:0] v);
    for (int i = 0; i < 9; i++) begin
      @(negedge clk); bank_wr = 1; bank_bit = v[i];
    end
    @(negedge clk); bank_wr = 0;
  endtask

  task automatic access(input logic [15:0] a, input bit we, input logic [7:0] d,
                        output logic [7:0] rd, output logic [23:0] sa,
                        output logic [1:0] lanes, output bit sio,
                        output logic [1:0] swe, output bit soe, output bit rel_ok);
    bit ack_prev = 0;
    sa = 0; lanes = 0; sio = 0; swe = 0; soe = 0; rel_ok = 0;
    @(negedge clk); s_addr = a; s_we = we; s_wdata = d; s_start = 1;
    @(negedge clk); s_start = 0;
    for (int n = 0; n < 40; n++) begin
      if (bus_uds | bus_lds) begin
        sa = {bus_addr, 1'b0};
        lanes = {bus_uds, bus_lds};
        sio = sio | io_sel;
        swe = swe | {ram_we_hi, ram_we_lo};
        soe = soe | ram_oe_hi | ram_oe_lo;
      end
      if (ack_prev) begin rel_ok = !s_wait; break; end
      ack_prev = bus_ack;
      @(negedge clk);
    end
    rd = s_rdata;
  endtask

  localparam logic [33:0] VEC [7] = '{
    {9'h000, 16'h8012, 8'hF6, 1'b0},
    {9'h000, 16'h8013, 8'h09, 1'b0},
    {9'h1FF, 16'h8004, 8'hFF, 1'b0},
    {9'h1FE, 16'h8101, 8'hFF, 1'b0},
    {9'h1FD, 16'h80A4, 8'hAD, 1'b0},
    {9'h142, 16'hB0FB, 8'h7D, 1'b1},
    {9'h0AB, 16'hFFFE, 8'h00, 1'b0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd; logic [23:0] sa; logic [1:0] ln, swe; bit sio, soe, rel;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!s_wait && !bus_breq && !bus_uds && !bus_lds, "reset R4", {s_wait, bus_breq, bus_uds, bus_lds}, 0);

    // R2: reset bank zero, R1 mapping
    access(16'h8002, 0, 0, rd, sa, ln, sio, swe, soe, rel);
    chk(sa == 24'h000002, "R2 reset bank R1", sa, 24'h000002);

    // R10: below window ignored
    @(negedge clk); s_addr = 16'h7FFF; s_we = 0; s_start = 1;
    @(negedge clk); s_start = 0;
    for (int i = 0; i < 3; i++) begin
      chk(!s_wait && !bus_breq, "R10 no wait", {s_wait, bus_breq}, 0);
      @(negedge clk);
    end

    for (int v = 0; v < 7; v++) begin
      logic [8:0] b; logic [15:0] a; logic [7:0] e; bit io;
      {b, a, e, io} = VEC[v];
      set_bank(b);
      access(a, 0, 0, rd, sa, ln, sio, swe, soe, rel);
      chk(sa == {b, a[14:1], 1'b0}, "R1 R2 address", sa, {b, a[14:1], 1'b0});
      chk(ln == (a[0] ? 2'b01 : 2'b10), "R3 lane", ln, a[0] ? 2'b01 : 2'b10);
      chk(rd == e, "R5 R9 read data", rd, e);
      chk(sio == io, "R8 io decode", sio, io);
      chk(rel, "R4 wait release", rel, 1);
    end

    // R6 / R11 work RAM writes
    poke(8'h02, 16'hDEAD);
    poke(8'h03, 16'hDEBE);
    set_bank(9'h1FF);
    access(16'h8004, 1, 8'h55, rd, sa, ln, sio, swe, soe, rel);
    @(negedge clk);
    chk(mem[2] == 16'h55AD, "R6 even write", mem[2], 16'h55AD);
    chk(swe == 2'b10, "R6 even we lane", swe, 2'b10);
    access(16'h8005, 1, 8'h00, rd, sa, ln, sio, swe, soe, rel);
    @(negedge clk);
    chk(mem[2] == 16'h5500, "R6 odd write 00", mem[2], 16'h5500);
    chk(swe == 2'b01, "R6 odd we lane", swe, 2'b01);
    access(16'h8005, 1, 8'hFF, rd, sa, ln, sio, swe, soe, rel);
    @(negedge clk);
    chk(mem[2] == 16'h55FF, "R6 odd write FF", mem[2], 16'h55FF);

    access(16'h8006, 0, 0, rd, sa, ln, sio, swe, soe, rel);
    chk(rd == 8'hFF, "R11 rmw read", rd, 8'hFF);
    access(16'h8006, 1, rd + 8'h01, rd, sa, ln, sio, swe, soe, rel);
    @(negedge clk);
    chk(mem[3] == 16'h00BE, "R11 rmw store", mem[3], 16'h00BE);

    // R7 output enables
    @(negedge clk); ext_uds = 1; ext_lds = 0;
    #1;
    chk(ram_oe_hi && !ram_oe_lo, "R7 oe follows ext", {ram_oe_hi, ram_oe_lo}, 2'b10);
    access(16'h8004, 0, 0, rd, sa, ln, sio, swe, soe, rel);
    chk(!soe, "R7 oe quiet on bridge", soe, 0);
    chk(rd == 8'hFF, "R5 read with ext strobe", rd, 8'hFF);
    ext_uds = 0;

    // R6: no RAM write outside work RAM; R8 io write
    set_bank(9'h000);
    access(16'h8002, 1, 8'h33, rd, sa, ln, sio, swe, soe, rel);
    chk(swe == 2'b00, "R6 no we outside RAM", swe, 0);
    set_bank(9'h142);
    access(16'hB0FB, 1, 8'h21, rd, sa, ln, sio, swe, soe, rel);
    chk(sio && ln == 2'b01, "R8 io write", {sio, ln}, 3'b101);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule